// File: doc/BRIEF.md
# UART Interrupt Level Generator

This block produces the interrupt request levels for a 16550-style UART. It reads the status of the transmit and receive data paths and turns it into one transmit level, one receive level and a combined pin level. When FIFO mode is off, the transmit and receive levels follow whether the single holding registers hold data. When FIFO mode is on, they follow how full each FIFO is compared with a programmable trigger threshold. A receive data timeout can also raise the receive level.

The FIFOs, the serial shifters, the baud generator and the register bus sit outside this block. Their state arrives as plain inputs: the fill counts, the holding-register flags, the trigger thresholds and the timeout level. Each source has an enable mask that decides whether it reaches the combined pin. All three outputs are registered on the system clock, so every change on the inputs reaches the outputs one clock later.

Top module: `uart_irq_gen`

## Requirements
- R1: With FIFO mode off (`fifoEn`=0), `txIrq` is 1 when the transmit holding register is empty (`thrFull`=0) and 0 when it holds a byte (`thrFull`=1).
- R2: With FIFO mode off, `rxIrq` is 1 when the receive holding register holds a byte (`rhrFull`=1) and 0 when it is empty.
- R3: With FIFO mode on (`fifoEn`=1), `txIrq` is 1 when `txFill` is 0 or `txFill` < `txTrig`. Otherwise it is 0, and a fill equal to the threshold counts as reached, giving 0.
- R4: With FIFO mode on, `rxIrq` is 1 when `rxTimeout` is 1, or when `rxFill` is nonzero and `rxFill` >= `rxTrig`. Otherwise it is 0. Once `rxTimeout` drops, the threshold rule alone decides `rxIrq`.
- R5: Inputs that belong to the inactive mode have no effect on any output. With FIFO mode off, this covers the fill counts, the thresholds and `rxTimeout`. With FIFO mode on, it covers `thrFull` and `rhrFull`.
- R6: Every output changes exactly one clock after the inputs that cause the change, and this includes a change of `fifoEn`. Between rising edges the outputs hold steady.
- R7: While `rstN` is 0, the outputs are `txIrq`=1, `rxIrq`=0 and `irqPin` at its idle level (0 by default), and this takes effect without waiting for a clock edge.
- R8: `irqPin` is ((tx level AND `txMask`) OR (rx level AND `rxMask`)), active high by default, and is registered on the same edge as `txIrq` and `rxIrq`.
- R9: With both `txMask` and `rxMask` at 0, `irqPin` stays at its idle level whatever the tx and rx levels are.
- R10: Fill counts and thresholds cover the full range 0 to 64, and the comparisons in R3 and R4 hold at 64 as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoEn | input | 1 | FIFO mode select: 1 = threshold rules, 0 = holding-register rules |
| thrFull | input | 1 | Transmit holding register holds a byte |
| rhrFull | input | 1 | Receive holding register holds a byte |
| txFill | input | 7 | Transmit FIFO fill count, 0 to 64 |
| rxFill | input | 7 | Receive FIFO fill count, 0 to 64 |
| txTrig | input | 7 | Transmit trigger threshold |
| rxTrig | input | 7 | Receive trigger threshold |
| rxTimeout | input | 1 | Receive data timeout level, held until the FIFO is read |
| txMask | input | 1 | Lets the transmit level reach the pin |
| rxMask | input | 1 | Lets the receive level reach the pin |
| txIrq | output | 1 | Registered transmit interrupt level |
| rxIrq | output | 1 | Registered receive interrupt level |
| irqPin | output | 1 | Registered combined interrupt pin |

## Verification
The bench sweeps every fill and threshold pair from 0 to 64 for both directions. The points it goes after are equal fill and threshold, an empty FIFO with a zero threshold, and a fill of 64. A design that used a strict comparison, let an empty FIFO pass the receive threshold, or cut the count width would give the wrong level on exactly those points. In each mode the bench also toggles the inputs that belong to the other mode, which exposes a mode multiplexer wired backwards or a timeout left active outside FIFO mode. It also looks at the outputs half a clock after a mode switch and after an asynchronous reset, which catches an extra register stage, a combinational path, or reset that waits for a clock.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  // Threshold results from the datapath comparators
  typedef struct packed {
    logic txEmpty;
    logic txBelow;
    logic rxReached;
  } cmpStat_t;

  // Next-cycle level strobes handed from control to the output stage
  typedef struct packed {
    logic txLvl;
    logic rxLvl;
  } levelStrobe_t;

endpackage

// File: rtl/uirq_cmp.sv
module uirq_cmp #(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0]  txFill,
  input  logic [CNT_W-1:0]  txTrig,
  input  logic [CNT_W-1:0]  rxFill,
  input  logic [CNT_W-1:0]  rxTrig,
  output uirq_pkg::cmpStat_t stat
);

  always_comb begin
    stat.txEmpty   = (txFill == '0);
    stat.txBelow   = (txFill < txTrig);
    // an empty receive FIFO never counts as having reached its threshold
    stat.rxReached = (rxFill != '0) && (rxFill >= rxTrig);
  end

endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl (
  input  logic                    fifoEn,
  input  logic                    thrFull,
  input  logic                    rhrFull,
  input  logic                    rxTimeout,
  input  uirq_pkg::cmpStat_t      stat,
  output uirq_pkg::levelStrobe_t  strobe
);

  always_comb begin
    if (fifoEn) begin
      strobe.txLvl = stat.txEmpty | stat.txBelow;
      strobe.rxLvl = stat.rxReached | rxTimeout;
    end else begin
      strobe.txLvl = ~thrFull;
      strobe.rxLvl = rhrFull;
    end
  end

endmodule

// File: rtl/uirq_out.sv
module uirq_out #(
  parameter bit PIN_ACTIVE_LOW = 1'b0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  uirq_pkg::levelStrobe_t  strobe,
  input  logic                    txMask,
  input  logic                    rxMask,
  output logic                    txIrq,
  output logic                    rxIrq,
  output logic                    irqPin
);

  localparam logic IDLE_LEVEL = PIN_ACTIVE_LOW;

  logic anyNext;
  logic pinNext;

  assign anyNext = (strobe.txLvl & txMask) | (strobe.rxLvl & rxMask);

  generate
    if (PIN_ACTIVE_LOW) begin : g_pinLow
      assign pinNext = ~anyNext;
    end else begin : g_pinHigh
      assign pinNext = anyNext;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIrq  <= 1'b1;
      rxIrq  <= 1'b0;
      irqPin <= IDLE_LEVEL;
    end else begin
      txIrq  <= strobe.txLvl;
      rxIrq  <= strobe.rxLvl;
      irqPin <= pinNext;
    end
  end

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
  parameter int FIFO_DEPTH     = 64,
  parameter bit PIN_ACTIVE_LOW = 1'b0,
  parameter int CNT_W          = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             thrFull,
  input  logic             rhrFull,
  input  logic [CNT_W-1:0] txFill,
  input  logic [CNT_W-1:0] rxFill,
  input  logic [CNT_W-1:0] txTrig,
  input  logic [CNT_W-1:0] rxTrig,
  input  logic             rxTimeout,
  input  logic             txMask,
  input  logic             rxMask,
  output logic             txIrq,
  output logic             rxIrq,
  output logic             irqPin
);

  uirq_pkg::cmpStat_t     stat;
  uirq_pkg::levelStrobe_t strobe;

  uirq_cmp #(.CNT_W(CNT_W)) u_cmp (
    .txFill (txFill),
    .txTrig (txTrig),
    .rxFill (rxFill),
    .rxTrig (rxTrig),
    .stat   (stat)
  );

  uirq_ctrl u_ctrl (
    .fifoEn    (fifoEn),
    .thrFull   (thrFull),
    .rhrFull   (rhrFull),
    .rxTimeout (rxTimeout),
    .stat      (stat),
    .strobe    (strobe)
  );

  uirq_out #(.PIN_ACTIVE_LOW(PIN_ACTIVE_LOW)) u_out (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .txMask (txMask),
    .rxMask (rxMask),
    .txIrq  (txIrq),
    .rxIrq  (rxIrq),
    .irqPin (irqPin)
  );

endmodule

// File: rtl/uart_irq_gen_chk.sv
module uart_irq_gen_chk #(
  parameter int CNT_W          = 7,
  parameter bit PIN_ACTIVE_LOW = 1'b0
) (
  input logic             clk,
  input logic             rstN,
  input logic             fifoEn,
  input logic             thrFull,
  input logic             rhrFull,
  input logic [CNT_W-1:0] txFill,
  input logic [CNT_W-1:0] rxFill,
  input logic [CNT_W-1:0] txTrig,
  input logic [CNT_W-1:0] rxTrig,
  input logic             rxTimeout,
  input logic             txMask,
  input logic             rxMask,
  input logic             txIrq,
  input logic             rxIrq,
  input logic             irqPin
);

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  always @(negedge clk) begin
    if (!rstN) begin
      AST_RESET_DEFAULTS: assert (txIrq && !rxIrq && (irqPin == PIN_ACTIVE_LOW)); // R7
    end
  end

  AST_TX_HOLDING: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !fifoEn) |=> (txIrq == !$past(thrFull))); // R1

  AST_RX_HOLDING: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !fifoEn) |=> (rxIrq == $past(rhrFull))); // R2

  AST_TX_THRESHOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && fifoEn && (txFill >= txTrig) && (txFill != '0)) |=> !txIrq); // R3

  AST_TX_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && fifoEn && (txFill == '0)) |=> txIrq); // R3

  AST_RX_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && fifoEn && rxTimeout) |=> rxIrq); // R4

  AST_RX_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && fifoEn && !rxTimeout && (rxFill == '0)) |=> !rxIrq); // R4

  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !txMask && !rxMask) |=> (irqPin == PIN_ACTIVE_LOW)); // R9

  AST_PIN_COMBINE: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |=> (irqPin == (PIN_ACTIVE_LOW ^
                   ((txIrq & $past(txMask)) | (rxIrq & $past(rxMask)))))); // R8

endmodule

bind uart_irq_gen uart_irq_gen_chk #(.CNT_W(CNT_W), .PIN_ACTIVE_LOW(PIN_ACTIVE_LOW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fifoEn    (fifoEn),
  .thrFull   (thrFull),
  .rhrFull   (rhrFull),
  .txFill    (txFill),
  .rxFill    (rxFill),
  .txTrig    (txTrig),
  .rxTrig    (rxTrig),
  .rxTimeout (rxTimeout),
  .txMask    (txMask),
  .rxMask    (rxMask),
  .txIrq     (txIrq),
  .rxIrq     (rxIrq),
  .irqPin    (irqPin)
);

// File: tb/uart_irq_gen_tb.sv
module uart_irq_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int CW         = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEn = 1'b0, thrFull = 1'b0, rhrFull = 1'b0, rxTimeout = 1'b0;
  logic txMask = 1'b0, rxMask = 1'b0;
  logic [CW-1:0] txFill = '0, rxFill = '0, txTrig = '0, rxTrig = '0;
  logic txIrq, rxIrq, irqPin;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_gen u_dut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .thrFull(thrFull), .rhrFull(rhrFull),
    .txFill(txFill), .rxFill(rxFill), .txTrig(txTrig), .rxTrig(rxTrig),
    .rxTimeout(rxTimeout), .txMask(txMask), .rxMask(rxMask),
    .txIrq(txIrq), .rxIrq(rxIrq), .irqPin(irqPin)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expTx(logic en, logic thr, int fill, int trig);
    if (!en) return !thr;
    return (fill == 0) || (fill < trig);
  endfunction

  function automatic logic expRx(logic en, logic rhr, int fill, int trig, logic tmo);
    if (!en) return rhr;
    return tmo || ((fill != 0) && (fill >= trig));
  endfunction

  task automatic checkAll(input string req, input logic eTx, input logic eRx, input logic tm, input logic rm);
    chk({req, " txIrq"}, txIrq, eTx);
    chk({req, " rxIrq"}, rxIrq, eRx);
    chk({req, " irqPin (R8)"}, irqPin, (eTx & tm) | (eRx & rm));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R7: reset defaults
    repeat (2) @(negedge clk);
    chk("R7 reset txIrq", txIrq, 1'b1);
    chk("R7 reset rxIrq", rxIrq, 1'b0);
    chk("R7 reset irqPin", irqPin, 1'b0);
    rstN = 1'b1;

    // R1 R2 R5 R8 R9: holding-register mode with FIFO-side inputs toggled
    for (int v = 0; v < 256; v++) begin
      fifoEn    = 1'b0;
      thrFull   = v[0];
      rhrFull   = v[1];
      rxTimeout = v[2];
      txMask    = v[3];
      rxMask    = v[4];
      txFill    = CW'((v * 13) % (DEPTH + 1));
      rxFill    = CW'((v * 29) % (DEPTH + 1));
      txTrig    = CW'((v * 7) % (DEPTH + 1));
      rxTrig    = CW'((v * 3) % (DEPTH + 1));
      @(negedge clk);
      checkAll("R1 R2 R5 R9 holding", !v[0], v[1], v[3], v[4]);
    end

    // R3 R4 R5 R10: full sweep of fill against threshold, 0..64
    for (int i = 0; i <= DEPTH; i++) begin
      for (int j = 0; j <= DEPTH; j++) begin
        logic tmo, tm, rm, hf;
        tmo = ((i * 7 + j) % 11) == 0;
        tm  = ((i + j) % 4) != 1;
        rm  = ((i + j) % 4) != 2;
        hf  = ((i ^ j) & 1) != 0;
        fifoEn    = 1'b1;
        txFill    = CW'(i);
        txTrig    = CW'(j);
        rxFill    = CW'(j);
        rxTrig    = CW'(i);
        rxTimeout = tmo;
        txMask    = tm;
        rxMask    = rm;
        thrFull   = hf;
        rhrFull   = !hf;
        @(negedge clk);
        checkAll("R3 R4 R5 R10 fifo", expTx(1'b1, hf, i, j), expRx(1'b1, !hf, j, i, tmo), tm, rm);
      end
    end

    // R4: timeout release returns to threshold rule
    fifoEn = 1'b1; rxFill = CW'(3); rxTrig = CW'(8); rxTimeout = 1'b1; rxMask = 1'b1; txMask = 1'b0;
    @(negedge clk);
    chk("R4 timeout raises rxIrq", rxIrq, 1'b1);
    rxTimeout = 1'b0;
    @(negedge clk);
    chk("R4 timeout cleared below threshold", rxIrq, 1'b0);

    // R9: both masks cleared while both levels are high
    txFill = '0; rxFill = CW'(DEPTH); rxTrig = CW'(1); txMask = 1'b0; rxMask = 1'b0;
    @(negedge clk);
    chk("R9 idle with tx level high", txIrq, 1'b1);
    chk("R9 pin idle", irqPin, 1'b0);

    // R6: mode switch latency
    fifoEn = 1'b0; thrFull = 1'b1; txMask = 1'b1;
    @(negedge clk);
    chk("R6 setup txIrq", txIrq, 1'b0);
    fifoEn = 1'b1; txFill = '0;
    #1;
    chk("R6 txIrq holds before edge", txIrq, 1'b0);
    @(posedge clk);
    #1;
    chk("R6 txIrq after one edge", txIrq, 1'b1);
    chk("R6 irqPin after one edge", irqPin, 1'b1);

    // R7: asynchronous reset mid-run
    @(negedge clk);
    rxTimeout = 1'b1; rxMask = 1'b1;
    @(negedge clk);
    chk("R7 pre-reset rxIrq", rxIrq, 1'b1);
    #1;
    rstN = 1'b0;
    #1;
    chk("R7 async txIrq", txIrq, 1'b1);
    chk("R7 async rxIrq", rxIrq, 1'b0);
    chk("R7 async irqPin", irqPin, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R4 after reset timeout level", rxIrq, 1'b1);

    finishRun();
  end

endmodule